// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes (19-bit address, 8-bit data). The host raises a request with a direction, address and write byte. The controller acknowledges it only when no access is in progress. It then plays out a fixed strobe sequence on the active-low chip, write and output enables. The sequence is built so that every minimum pulse width, setup time and bus turnaround time of the memory is met at clock granularity. Read data comes back with a one-cycle valid pulse.

Each timing minimum is given in nanoseconds as a parameter, together with the clock period. Every phase length is the nanosecond figure divided by the period, rounded up, and never less than one cycle. A write waits for the output-disable turnaround first. It then pulses write enable while output enable stays high the whole time. A read holds chip and output enable low for the full access time. Chip enable is released after every access, so the memory drops to standby between requests. The bidirectional data pad is built outside this block from `sram_dq_out`, `sram_dq_in` and `sram_dq_oe`.

With a 10 ns clock and the default parameters, the phases are 2 turnaround cycles, 5 write-pulse cycles and 6 read-access cycles.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is low and immediately after it, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A read holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 with `sram_dq_oe`=0 for ACC cycles, starting in the cycle after acceptance. ACC is the largest of ceil(access/period), ceil(output-enable access/period) and ceil(read cycle/period)-1. Write or output enable is never low while chip enable is high.
- R3: Read data is sampled from `sram_dq_in` at the clock edge that ends the last access cycle. In the following cycle, `rd_valid` is 1 for exactly one cycle and `rd_data` carries the sampled byte.
- R4: A write starts with TURN = ceil(high-Z time/period) cycles of `sram_ce_n`=0, `sram_we_n`=1, `sram_oe_n`=1 and `sram_dq_oe`=0. Write data is never driven while output enable is low or less than TURN cycles after it went high.
- R5: The turnaround is followed by PULSE cycles of `sram_ce_n`=0, `sram_we_n`=0 and `sram_dq_oe`=1. PULSE is the largest of ceil(write pulse/period), ceil(data setup/period) and ceil(write cycle/period)-TURN-1. `sram_oe_n` stays 1 throughout a write.
- R6: The write ends with one hold cycle in which `sram_ce_n` and `sram_we_n` are both 1 while `sram_dq_oe` is still 1 and address and data are unchanged.
- R7: `req_ack` is 1 exactly in a cycle where the controller is idle and `req` is 1. An idle cycle with all three strobes at 1 and no drive follows every access, and a request held during an access is taken only after that.
- R8: `sram_addr` holds the accepted address from the first access cycle through the hold or release cycle. `sram_dq_out` holds the accepted byte throughout the pulse and hold cycles.
- R9: A read returns the byte written last to that address. Addresses 0 and 0x7FFFF are kept apart, and bytes 0x00, 0xFF and mixed patterns survive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until acknowledged |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Host word address |
| req_wdata | input | 8 | Byte to write |
| req_ack | output | 1 | Request taken this cycle |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | 8 | Byte read from memory |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 19 | Memory address |
| sram_dq_out | output | 8 | Byte toward the data pad |
| sram_dq_in | input | 8 | Byte from the data pad |
| sram_dq_oe | output | 1 | Pad drive enable, active high |

## Verification
The assertions run on every cycle and guard the strobe legality rules. These are: no enable without chip enable, no drive during a read, output enable high during writes, and the turnaround and write-pulse minimums counted in cycles. They also guard address and data stability at the write-ending edge, the single-cycle valid pulse and acknowledge only from idle. The exact phase lengths, the sampling cycle of read data, and the data integrity across a write followed by a read can only be shown by the bench scenarios. Those scenarios cover back-to-back requests held during busy phases and the extreme addresses, with a memory model that returns garbage before the access time has elapsed.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_W_TURN,
    PH_W_PULSE,
    PH_W_HOLD,
    PH_R_ACCESS,
    PH_R_RELEASE
  } phase_t;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobe_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic strobe_t phase_strobes(input phase_t p);
    strobe_t s;
    case (p)
      PH_W_TURN:    s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
      PH_W_PULSE:   s = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
      PH_W_HOLD:    s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
      PH_R_ACCESS:  s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
      default:      s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain <= '0;
    else if (load)             remain <= load_len - CNT_W'(1);
    else if (remain != '0)     remain <= remain - CNT_W'(1);
  end

  assign last = (remain == '0);

endmodule

// File: rtl/sram_pin_driver.sv
module sram_pin_driver
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            nxt_ph,
  input  logic              take_op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  strobe_t nxt_s;
  assign nxt_s = phase_strobes(nxt_ph);

  // strobes come straight from flops so the memory never sees decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= nxt_s.ce_n;
      we_n  <= nxt_s.we_n;
      oe_n  <= nxt_s.oe_n;
      dq_oe <= nxt_s.drive;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take_op) begin
      addr_q  <= op_addr;
      wdata_q <= op_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_no_drive_in_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 10,
  parameter int T_ACC_NS     = 55,
  parameter int T_OE_ACC_NS  = 25,
  parameter int T_RDCYC_NS   = 55,
  parameter int T_WEPULSE_NS = 45,
  parameter int T_DSETUP_NS  = 30,
  parameter int T_WRCYC_NS   = 55,
  parameter int T_HIGHZ_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);
  localparam int TURN_CYC  = ns_to_cyc(T_HIGHZ_NS, CLK_NS);
  localparam int PULSE_CYC = max3(ns_to_cyc(T_WEPULSE_NS, CLK_NS),
                                  ns_to_cyc(T_DSETUP_NS, CLK_NS),
                                  ns_to_cyc(T_WRCYC_NS, CLK_NS) - TURN_CYC - 1);
  localparam int ACC_CYC   = max3(ns_to_cyc(T_ACC_NS, CLK_NS),
                                  ns_to_cyc(T_OE_ACC_NS, CLK_NS),
                                  ns_to_cyc(T_RDCYC_NS, CLK_NS) - 1);
  localparam int LEN_MAX   = max3(TURN_CYC, PULSE_CYC, ACC_CYC);
  localparam int CNT_W     = $clog2(LEN_MAX + 1);

  phase_t           cur_ph, nxt_ph;
  logic             ph_last, ph_load, accept, capture;
  logic [CNT_W-1:0] nxt_len;

  assign accept  = (cur_ph == PH_IDLE) && req;
  assign req_ack = accept;
  assign capture = (cur_ph == PH_R_ACCESS) && ph_last;
  assign ph_load = (nxt_ph != cur_ph);

  always_comb begin
    nxt_ph = cur_ph;
    case (cur_ph)
      PH_IDLE:      if (req) nxt_ph = req_we ? PH_W_TURN : PH_R_ACCESS;
      PH_W_TURN:    if (ph_last) nxt_ph = PH_W_PULSE;
      PH_W_PULSE:   if (ph_last) nxt_ph = PH_W_HOLD;
      PH_W_HOLD:    nxt_ph = PH_IDLE;
      PH_R_ACCESS:  if (ph_last) nxt_ph = PH_R_RELEASE;
      PH_R_RELEASE: nxt_ph = PH_IDLE;
      default:      nxt_ph = PH_IDLE;
    endcase
  end

  always_comb begin
    case (nxt_ph)
      PH_W_TURN:   nxt_len = CNT_W'(TURN_CYC);
      PH_W_PULSE:  nxt_len = CNT_W'(PULSE_CYC);
      PH_R_ACCESS: nxt_len = CNT_W'(ACC_CYC);
      default:     nxt_len = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_ph <= PH_IDLE;
    else        cur_ph <= nxt_ph;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_len (nxt_len),
    .last     (ph_last)
  );

  sram_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt_ph   (nxt_ph),
    .take_op  (accept),
    .op_addr  (req_addr),
    .op_wdata (req_wdata),
    .capture  (capture),
    .dq_in    (sram_dq_in),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe),
    .addr_q   (sram_addr),
    .wdata_q  (sram_dq_out),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // run-length counters at the pins, used only by the checks below
  logic [CNT_W-1:0] oe_hi_run, we_lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_run <= '0;
      we_lo_run <= '0;
    end else begin
      if (!sram_oe_n)                       oe_hi_run <= '0;
      else if (oe_hi_run != CNT_W'(LEN_MAX)) oe_hi_run <= oe_hi_run + CNT_W'(1);
      if (sram_we_n)                        we_lo_run <= '0;
      else if (we_lo_run != CNT_W'(LEN_MAX)) we_lo_run <= we_lo_run + CNT_W'(1);
    end
  end

  assert_enable_needs_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n || !sram_oe_n) |-> !sram_ce_n);

  assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_hi_run >= CNT_W'(TURN_CYC)));

  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_lo_run >= CNT_W'(PULSE_CYC)));

  assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  assert_hold_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out)));

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  assert_ack_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (sram_ce_n && sram_we_n && sram_oe_n && !rd_valid));

endmodule

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;
  localparam int PER = 10;

  function automatic int up(input int ns);
    int c;
    c = ns / PER;
    if (c * PER < ns) c++;
    if (c == 0) c = 1;
    return c;
  endfunction
  function automatic int bigger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_TURN  = up(20);
  localparam int N_PULSE = bigger(bigger(up(45), up(30)), up(55) - N_TURN - 1);
  localparam int N_ACC   = bigger(bigger(up(55), up(25)), up(55) - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, sram_dq_in = 8'hEE;
  logic req_ack, rd_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  rd_data, sram_dq_out;
  logic [18:0] sram_addr;

  always #(PER/2) clk = ~clk;

  sram_strobe_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ack(req_ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
    .sram_dq_oe(sram_dq_oe)
  );

  int checks = 0, errors = 0;

  function automatic string tg(input int n);
    case (n)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // expected pin state per cycle: strobes packed as {ce_n,we_n,oe_n,drive}
  typedef struct {
    logic [3:0]  pins;
    bit          has_addr;
    bit          valid;
    logic [18:0] a;
    logic [7:0]  d;
    int          tag;
  } cyc_t;

  cyc_t        plan_q[$];
  logic [7:0]  shadow [int];
  logic [7:0]  mem    [int];
  bit          took = 1'b0;

  task automatic push_op(input bit w, input logic [18:0] a, input logic [7:0] d);
    cyc_t c;
    c.has_addr = 1'b1; c.a = a; c.valid = 1'b0; c.d = d;
    if (w) begin
      for (int i = 0; i < N_TURN; i++)  begin c.pins = 4'b0110; c.tag = 4; plan_q.push_back(c); end
      for (int i = 0; i < N_PULSE; i++) begin c.pins = 4'b0011; c.tag = 5; plan_q.push_back(c); end
      c.pins = 4'b1111; c.tag = 6; plan_q.push_back(c);
      shadow[int'(a)] = d;
    end else begin
      for (int i = 0; i < N_ACC; i++)   begin c.pins = 4'b0100; c.tag = 2; plan_q.push_back(c); end
      c.pins = 4'b1110; c.tag = 3; c.valid = 1'b1;
      c.d = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      plan_q.push_back(c);
    end
  endtask

  // memory model state
  bit          wr_open = 1'b0, rd_open = 1'b0;
  logic [18:0] wr_a;
  logic [7:0]  wr_d;
  longint      rd_t0 = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe} == 4'b1110, "R1", "strobes in reset",
          {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
      chk(!rd_valid && rd_data == 8'h00, "R1", "read outputs in reset", {rd_valid, rd_data}, 0);
    end else begin
      cyc_t c;
      bit idle;
      idle = (plan_q.size() == 0);
      if (idle) begin
        c.pins = 4'b1110; c.has_addr = 1'b0; c.valid = 1'b0; c.a = '0; c.d = '0; c.tag = 7;
      end else c = plan_q.pop_front();
      chk({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe} == c.pins, tg(c.tag), "strobes",
          {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, c.pins);
      chk(rd_valid == c.valid, "R3", "rd_valid", rd_valid, c.valid);
      if (c.valid) chk(rd_data == c.d, "R9", "rd_data", rd_data, c.d);
      if (c.has_addr) chk(sram_addr == c.a, "R8", "sram_addr", sram_addr, c.a);
      if (c.pins[0]) chk(sram_dq_out == c.d, "R8", "sram_dq_out", sram_dq_out, c.d);
      chk(req_ack == (idle && req), "R7", "req_ack", req_ack, idle && req);
      // memory model: write committed when the write window closes
      if (!sram_ce_n && !sram_we_n) begin
        wr_open = 1'b1; wr_a = sram_addr; wr_d = sram_dq_out;
      end else if (wr_open) begin
        mem[int'(wr_a)] = wr_d; wr_open = 1'b0;
      end
      // read data only valid once 55 ns have elapsed since the enables fell
      if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
        if (!rd_open) begin rd_open = 1'b1; rd_t0 = longint'($time) - PER/2; end
        if (longint'($time) + PER/2 - rd_t0 >= 55)
          sram_dq_in = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
        else sram_dq_in = 8'hEE;
      end else begin
        rd_open = 1'b0; sram_dq_in = 8'hEE;
      end
      if (req && req_ack) begin
        push_op(req_we, req_addr, req_wdata);
        took = 1'b1;
      end
    end
  end

  task automatic op(input bit w, input logic [18:0] a, input logic [7:0] d, input int gap);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    forever begin
      @(posedge clk); #2;
      if (took) break;
    end
    took = 1'b0;
    req = 1'b0; req_we = 1'b0; req_addr = 19'h55555; req_wdata = 8'h99;
    for (int i = 0; i < gap; i++) begin @(posedge clk); #2; end
  endtask

  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_cnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R4 R5 R6: writes at both address extremes, with idle gaps
    op(1'b1, 19'h00000, 8'h3C, 2);
    op(1'b1, 19'h7FFFF, 8'hC3, 1);
    // R2 R3 R9: reads back, unwritten location returns model default
    op(1'b0, 19'h7FFFF, 8'h00, 0);
    op(1'b0, 19'h00000, 8'h00, 3);
    op(1'b0, 19'h12345, 8'h00, 0);
    // R7: back-to-back requests held while busy
    op(1'b1, 19'h00F0F, 8'hFF, 0);
    op(1'b1, 19'h00F10, 8'h00, 0);
    op(1'b1, 19'h40000, 8'hA5, 0);
    op(1'b0, 19'h00F0F, 8'h00, 0);
    op(1'b0, 19'h00F10, 8'h00, 0);
    op(1'b0, 19'h40000, 8'h00, 0);
    // R9: overwrite then read, and a write right after a read (turnaround)
    op(1'b1, 19'h40000, 8'h5A, 0);
    op(1'b0, 19'h40000, 8'h00, 0);
    op(1'b1, 19'h00001, 8'h81, 0);
    op(1'b0, 19'h00001, 8'h00, 0);
    op(1'b0, 19'h00000, 8'h00, 0);
    repeat (20) @(posedge clk);
    #2;
    chk(plan_q.size() == 0, "R7", "all planned cycles consumed", plan_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule